// File: doc/BRIEF.md
# Operand Bypass Selector

This block resolves read-after-write hazards in a five-stage in-order integer pipeline without stalling. For the instruction about to enter the execute stage it compares both source register numbers against the destination register numbers of the two older instructions still in flight. The younger of the two is held in the execute-output pipeline register and the older in the memory-output pipeline register. It then selects, for each ALU operand, either the register file read data or the value held in one of those two pipeline registers.

The block is purely combinational. It drives two 2-bit select codes and the two muxed operands that feed the ALU. Data width and register count are parameters. Load-use stalls, the register file and the ALU belong to neighbouring logic.

Top module: `opnd_bypass`

## Requirements
- R1: A select of 0 (register file data) is produced whenever no forwarding condition holds for that operand, for example because neither older stage writes registers or because no destination matches.
- R2: A select of 1 (execute-output value) is produced when the execute-output stage has its register-write bit set, its destination equals the source field and that destination is not register 0.
- R3: A select of 2 (memory-output value) is produced when the memory-output stage has its register-write bit set, its destination equals the source field and is not register 0, and the execute-output stage is not supplying the same operand.
- R4: When both stages write the same nonzero register that a source names, the select is 1: the younger result wins.
- R5: A source naming register 0 always gets select 0, whatever the older stages hold.
- R6: The two operands are decided independently, so one may take select 1 while the other takes select 2.
- R7: Each muxed operand equals the register file data for select 0, the execute-output value for select 1 and the memory-output value for select 2. Code 3 is never produced, and the mux treats it as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RW | Source register number for operand A of the instruction entering execute |
| src_b | input | RW | Source register number for operand B |
| rf_a | input | DW | Register file read data for operand A |
| rf_b | input | DW | Register file read data for operand B |
| xo_wr | input | 1 | Register-write bit of the execute-output stage |
| xo_dst | input | RW | Destination register of the execute-output stage |
| xo_val | input | DW | Result held in the execute-output stage |
| mo_wr | input | 1 | Register-write bit of the memory-output stage |
| mo_dst | input | RW | Destination register of the memory-output stage |
| mo_val | input | DW | Value held in the memory-output stage |
| sel_a | output | 2 | Select for operand A: 0 register file, 1 execute-output, 2 memory-output |
| sel_b | output | 2 | Select for operand B, same encoding |
| opnd_a | output | DW | Muxed operand A |
| opnd_b | output | DW | Muxed operand B |

## Verification
The bench sweeps every combination of both source fields, both write bits and both destinations for a four-register configuration. It targets the case where both stages match, where a design that lets the older stage win would feed a stale value to the ALU. It also covers sources and destinations of register 0, where a missing guard would forward a nonzero result into a register that must read zero. Directed patterns put operand A and operand B on different stages, which exposes a design that shares one comparison result between the operands.

// File: rtl/opnd_bypass.sv
module opnd_bypass #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic          xo_wr,
  input  logic [RW-1:0] xo_dst,
  input  logic [DW-1:0] xo_val,
  input  logic          mo_wr,
  input  logic [RW-1:0] mo_dst,
  input  logic [DW-1:0] mo_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  logic xo_live, mo_live;
  assign xo_live = xo_wr && (xo_dst != '0);
  assign mo_live = mo_wr && (mo_dst != '0);

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    logic hit_x, hit_m;
    hit_x = xo_live && (xo_dst == src);
    hit_m = mo_live && (mo_dst == src);
    if (hit_x)      pick = 2'd1;
    else if (hit_m) pick = 2'd2;
    else            pick = 2'd0;
  endfunction

  function automatic logic [DW-1:0] route(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      2'd1:    route = xo_val;
      2'd2:    route = mo_val;
      default: route = rf;
    endcase
  endfunction

  assign sel_a  = pick(src_a);
  assign sel_b  = pick(src_b);
  assign opnd_a = route(sel_a, rf_a);
  assign opnd_b = route(sel_b, rf_b);

endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic [RW-1:0] src_a,
  input logic [RW-1:0] src_b,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic          xo_wr,
  input logic [RW-1:0] xo_dst,
  input logic [DW-1:0] xo_val,
  input logic          mo_wr,
  input logic [RW-1:0] mo_dst,
  input logic [DW-1:0] mo_val,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b
);

  always_comb begin
    if (sel_a == 2'd1)
      assert_xo_legal_a_R2: assert (xo_wr && xo_dst == src_a && src_a != '0);
    if (sel_b == 2'd1)
      assert_xo_legal_b_R2: assert (xo_wr && xo_dst == src_b && src_b != '0);
    if (sel_a == 2'd2)
      assert_mo_legal_a_R3: assert (mo_wr && mo_dst == src_a && src_a != '0 &&
                                    !(xo_wr && xo_dst == src_a));
    if (sel_b == 2'd2)
      assert_mo_legal_b_R3: assert (mo_wr && mo_dst == src_b && src_b != '0 &&
                                    !(xo_wr && xo_dst == src_b));
    if (src_a != '0 && xo_wr && xo_dst == src_a)
      assert_young_wins_a_R4: assert (sel_a == 2'd1);
    if (src_a == '0)
      assert_zero_reg_a_R5: assert (sel_a == 2'd0 && opnd_a == rf_a);
    if (src_b == '0)
      assert_zero_reg_b_R5: assert (sel_b == 2'd0 && opnd_b == rf_b);
    assert_no_code3_R7: assert (sel_a != 2'd3 && sel_b != 2'd3);
    if (sel_a == 2'd0)
      assert_rf_path_a_R1: assert (opnd_a == rf_a);
    if (sel_b == 2'd2)
      assert_mo_path_b_R7: assert (opnd_b == mo_val);
  end

endmodule

bind opnd_bypass opnd_bypass_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
  .xo_wr(xo_wr), .xo_dst(xo_dst), .xo_val(xo_val),
  .mo_wr(mo_wr), .mo_dst(mo_dst), .mo_val(mo_val),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/tb_opnd_bypass.sv
module tb_opnd_bypass;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NREG = 4;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] src_a, src_b, xo_dst, mo_dst;
  logic [DW-1:0] rf_a, rf_b, xo_val, mo_val;
  logic          xo_wr, mo_wr;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  opnd_bypass #(.DW(DW), .NREG(NREG)) dut (
    .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
    .xo_wr(xo_wr), .xo_dst(xo_dst), .xo_val(xo_val),
    .mo_wr(mo_wr), .mo_dst(mo_dst), .mo_val(mo_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic int exp_sel(input int s, input int xw, input int xd, input int mw, input int md);
    if (s == 0) return 0;
    if (xw == 1 && xd == s) return 1;
    if (mw == 1 && md == s) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input int s, input int xw, input int xd, input int mw, input int md);
    if (s == 0) return "R5";
    if (xw == 1 && xd == s && mw == 1 && md == s) return "R4";
    if (xw == 1 && xd == s) return "R2";
    if (mw == 1 && md == s) return "R3";
    return "R1";
  endfunction

  function automatic logic [DW-1:0] exp_val(input int sel, input logic [DW-1:0] rf);
    return (sel == 1) ? xo_val : (sel == 2) ? mo_val : rf;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int sa, input int sb, input int xw, input int xd, input int mw, input int md);
    @(negedge clk);
    src_a = RW'(sa); src_b = RW'(sb);
    xo_wr = xw[0]; xo_dst = RW'(xd);
    mo_wr = mw[0]; mo_dst = RW'(md);
    #1;
  endtask

  initial begin
    src_a = '0; src_b = '0; xo_dst = '0; mo_dst = '0;
    xo_wr = 1'b0; mo_wr = 1'b0;
    rf_a = 8'h11; rf_b = 8'h22; xo_val = 8'hA5; mo_val = 8'h5C;
    @(negedge clk); #1;
    chk("R1", "idle sel_a", int'(sel_a), 0);
    chk("R1", "idle opnd_b", int'(opnd_b), 8'h22);

    for (int sa = 0; sa < NREG; sa++)
      for (int sb = 0; sb < NREG; sb++)
        for (int xw = 0; xw < 2; xw++)
          for (int xd = 0; xd < NREG; xd++)
            for (int mw = 0; mw < 2; mw++)
              for (int md = 0; md < NREG; md++) begin
                int ea, eb;
                apply(sa, sb, xw, xd, mw, md);
                ea = exp_sel(sa, xw, xd, mw, md);
                eb = exp_sel(sb, xw, xd, mw, md);
                chk(tag_of(sa, xw, xd, mw, md), "sel_a", int'(sel_a), ea);
                chk(tag_of(sb, xw, xd, mw, md), "sel_b", int'(sel_b), eb);
                chk("R7", "opnd_a", int'(opnd_a), int'(exp_val(ea, rf_a)));
                chk("R7", "opnd_b", int'(opnd_b), int'(exp_val(eb, rf_b)));
              end

    // R6: A from execute-output, B from memory-output, and the reverse
    apply(1, 2, 1, 1, 1, 2);
    chk("R6", "split sel_a", int'(sel_a), 1);
    chk("R6", "split sel_b", int'(sel_b), 2);
    chk("R6", "split opnd_a", int'(opnd_a), 8'hA5);
    chk("R6", "split opnd_b", int'(opnd_b), 8'h5C);
    apply(3, 1, 1, 1, 1, 3);
    chk("R6", "swap sel_a", int'(sel_a), 2);
    chk("R6", "swap sel_b", int'(sel_b), 1);

    // R4 with different data values
    xo_val = 8'h3E; mo_val = 8'hC1;
    apply(2, 2, 1, 2, 1, 2);
    chk("R4", "both match opnd_a", int'(opnd_a), 8'h3E);
    chk("R4", "both match opnd_b", int'(opnd_b), 8'h3E);

    // R5: zero source with every stage writing register 0
    apply(0, 0, 1, 0, 1, 0);
    chk("R5", "zero opnd_a", int'(opnd_a), 8'h11);
    chk("R5", "zero opnd_b", int'(opnd_b), 8'h22);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule